// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two N-bit two's-complement operands and returns a 2N-bit signed product. It does not use an adder array. It keeps a single accumulator register and adds one partial product per clock, so the area is one 2N-bit adder plus a small counter, and the cost is N cycles of latency.

A one-cycle start pulse, given while the block is idle, captures both operands and clears the accumulator. Over the next N clocks, step i adds the multiplicand, sign-extended to 2N bits and shifted left by i, whenever multiplier bit i is set. The top multiplier bit carries weight -2^(N-1), so its partial product is subtracted rather than added. This one change makes negative multipliers come out right. Carries out of the 2N-bit sum are dropped. When the last step completes, a one-cycle done flag is raised. The product output then keeps its value until the next start is accepted.

Top module: `seq_signed_mult`

## Requirements
- R1: The product output is the 2N-bit two's-complement product of the two signed operands. For example, at N=4, 0110 times 0011 gives 00010010.
- R2: A negative multiplicand is sign-extended to 2N bits, and any carry beyond 2N bits is dropped. For example, at N=4, 1010 times 0011 gives 11101110 (-18).
- R3: A negative multiplier gives the correct signed product, because its top bit is treated as weight -2^(N-1). For example, at N=4, 0011 times 1111 gives 11111101 (-3).
- R4: The most-negative operand squared gives +2^(2N-2) without overflow. For example, at N=4, 1000 times 1000 gives 01000000 (+64).
- R5: A start pulse sampled high while idle latches both operands. On the following cycle, product reads zero and done is low.
- R6: After the clock edge that accepts start, done rises after exactly N further clock edges and stays high for exactly one cycle.
- R7: A start pulse sampled while a multiplication is running has no effect. The operands latched earlier are used, and the latency does not change.
- R8: After done, the product output holds its value, with done low, until the next accepted start.
- R9: A synchronous reset leaves done low, product zero and the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a multiplication |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| product_o | output | 2N | Accumulated signed product |
| done_o | output | 1 | One-cycle pulse when product is final |

## Verification
The bench builds two instances, one with N=4 and one with N=8. At N=4 the operand space is small enough to try every one of the 256 pairs. This covers every sign combination, both most-negative corners and every carry that must be dropped. The N=8 instance takes random pairs plus its own most-negative corner. This exercises a wider counter and a sign-extension path that is twice as long, and shows that the latency follows N.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } smul_phase_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 accept,
    output logic                 step,
    output logic                 busy,
    output logic [$clog2(N)-1:0] idx,
    output logic                 done
);
    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        smul_phase_e   phase;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign accept = (st_q.phase == PH_IDLE) && start;
    assign step   = (st_q.phase == PH_RUN);
    assign busy   = step;
    assign idx    = st_q.cnt;
    assign done   = st_q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (rst)
        (step && idx == LAST) |=> (done && !busy)); // R6
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (step && idx != LAST && start) |=> (busy && idx == $past(idx) + 1'b1)); // R7
endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
    parameter int N = 4
) (
    input  logic [N-1:0]         mcand,
    input  logic [N-1:0]         mplier,
    input  logic [$clog2(N)-1:0] idx,
    output logic [2*N-1:0]       term
);
    localparam int W  = 2 * N;
    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] TOP = CW'(N - 1);

    logic [W-1:0] ext_w;
    logic [W-1:0] shifted_w;

    assign ext_w     = {{N{mcand[N-1]}}, mcand};
    assign shifted_w = ext_w << idx;

    always_comb begin
        if (!mplier[idx])     term = '0;
        else if (idx == TOP)  term = '0 - shifted_w;
        else                  term = shifted_w;
    end
endmodule

// File: rtl/seq_signed_mult.sv
module seq_signed_mult #(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N-1:0]     mcand_i,
    input  logic [N-1:0]     mplier_i,
    output logic [2*N-1:0]   product_o,
    output logic             done_o
);
    localparam int W  = 2 * N;
    localparam int CW = $clog2(N);

    typedef struct packed {
        logic [N-1:0] mcand;
        logic [N-1:0] mplier;
        logic [W-1:0] acc;
    } dp_s;

    dp_s dp_d, dp_q;

    logic          accept_w, step_w, busy_w, done_w;
    logic [CW-1:0] idx_w;
    logic [W-1:0]  term_w;

    smul_ctrl #(.N(N)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept_w),
        .step   (step_w),
        .busy   (busy_w),
        .idx    (idx_w),
        .done   (done_w)
    );

    smul_ppgen #(.N(N)) u_ppgen (
        .mcand  (dp_q.mcand),
        .mplier (dp_q.mplier),
        .idx    (idx_w),
        .term   (term_w)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept_w) begin
            dp_d.mcand  = mcand_i;
            dp_d.mplier = mplier_i;
            dp_d.acc    = '0;
        end else if (step_w) begin
            dp_d.acc = dp_q.acc + term_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign product_o = dp_q.acc;
    assign done_o    = done_w;

    logic [W-1:0] ref_w;
    assign ref_w = {{N{dp_q.mcand[N-1]}}, dp_q.mcand} * {{N{dp_q.mplier[N-1]}}, dp_q.mplier};

    AST_SIGNED_RESULT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (product_o == ref_w)); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        accept_w |=> (product_o == '0 && dp_q.mcand == $past(mcand_i) && !done_o)); // R5
    AST_OPERANDS_KEPT: assert property (@(posedge clk) disable iff (rst)
        busy_w |=> ($stable(dp_q.mcand) && $stable(dp_q.mplier))); // R7
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_w && !start) |=> $stable(product_o)); // R8
endmodule

// File: tb/seq_signed_mult_bench.sv
module seq_signed_mult_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       s4 = 1'b0, s8 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [7:0] p4;
    logic [15:0] p8;
    logic       d4, d8;

    seq_signed_mult #(.N(4)) u_seq_signed_mult (
        .clk(clk), .rst(rst), .start(s4), .mcand_i(a4), .mplier_i(b4),
        .product_o(p4), .done_o(d4));
    seq_signed_mult #(.N(8)) u_seq_signed_mult_w8 (
        .clk(clk), .rst(rst), .start(s8), .mcand_i(a8), .mplier_i(b8),
        .product_o(p8), .done_o(d8));

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;

    // {mcand, mplier, expected product} at N=4
    localparam logic [15:0] VEC [8] = '{
        {4'b0110, 4'b0011, 8'b00010010},   // R1  6*3
        {4'b1010, 4'b0011, 8'b11101110},   // R2 -6*3
        {4'b0011, 4'b1111, 8'b11111101},   // R3  3*-1
        {4'b1000, 4'b1000, 8'b01000000},   // R4 -8*-8
        {4'b0111, 4'b1000, 8'b11001000},   // R3  7*-8
        {4'b1000, 4'b0111, 8'b11001000},   // R2 -8*7
        {4'b0000, 4'b1000, 8'b00000000},   // R1  0*-8
        {4'b0111, 4'b0111, 8'b00110001}    // R1  7*7
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // N=4 run: start at a negedge, check clear, latency, pulse width
    task automatic run4(input logic [3:0] a, input logic [3:0] b, input string req,
                        input bit mid_start, output logic [7:0] res);
        @(negedge clk); a4 = a; b4 = b; s4 = 1'b1;
        @(negedge clk); s4 = 1'b0;
        check(p4 == 8'd0 && !d4, "R5", longint'(p4), 0);
        for (int k = 1; k < 4; k++) begin
            if (mid_start && k == 2) begin a4 = ~a; b4 = ~b; s4 = 1'b1; end
            @(negedge clk);
            s4 = 1'b0;
            if (d4) check(1'b0, "R6", k, 4);
        end
        @(negedge clk);
        check(d4, "R6", longint'(d4), 1);
        check(p4 == {{4{a[3]}}, a} * {{4{b[3]}}, b}, req,
              longint'($signed(p4)), longint'($signed(a)) * longint'($signed(b)));
        res = p4;
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input string req);
        @(negedge clk); a8 = a; b8 = b; s8 = 1'b1;
        @(negedge clk); s8 = 1'b0;
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            if (d8) check(1'b0, "R6", k, 8);
        end
        @(negedge clk);
        check(d8, "R6", longint'(d8), 1);
        check(p8 == {{8{a[7]}}, a} * {{8{b[7]}}, b}, req,
              longint'($signed(p8)), longint'($signed(a)) * longint'($signed(b)));
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(p4 == 8'd0 && !d4, "R9", longint'(p4), 0);
        check(p8 == 16'd0 && !d8, "R9", longint'(p8), 0);

        for (int i = 0; i < 8; i++) begin
            string req;
            case (i)
                1, 5:    req = "R2";
                2, 4:    req = "R3";
                3:       req = "R4";
                default: req = "R1";
            endcase
            run4(VEC[i][15:12], VEC[i][11:8], req, 1'b0, r);
            check(r == VEC[i][7:0], req, longint'(r), longint'(VEC[i][7:0]));
        end

        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run4(4'(a), 4'(b), "R1", 1'b0, r);

        // R7: start mid-run with other operands is ignored
        run4(4'b1101, 4'b0101, "R7", 1'b1, r);
        check(r == 8'b11110001, "R7", longint'(r), 241);

        // R8: product holds and done stays low while idle
        repeat (5) begin
            @(negedge clk);
            check(p4 == 8'b11110001 && !d4, "R8", longint'(p4), 241);
        end

        // R9: reset mid-run clears
        @(negedge clk); a4 = 4'b0111; b4 = 4'b0111; s4 = 1'b1;
        @(negedge clk); s4 = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(p4 == 8'd0 && !d4, "R9", longint'(p4), 0);

        run8(8'h80, 8'h80, "R4");
        check(p8 == 16'h4000, "R4", longint'(p8), 16384);
        run8(8'h7F, 8'h80, "R3");
        for (int i = 0; i < 300; i++)
            run8(8'($urandom), 8'($urandom), "R1");

        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule